// File: doc/BRIEF.md
# Interrupt Flag and Enable Aggregator

This block collects the interrupt requests of a peripheral adapter's internal sources (two timers and a shift register) into a 7-bit flag register, gates them with a 7-bit enable register, and drives a single level interrupt line toward the processor. A source announces an event with a one-cycle set pulse. Software acknowledges events in two ways: by writing a one-mask to the flag register, or as a side effect of reading a source's data register, which the surrounding adapter forwards to this block as a one-cycle clear strobe for that source.

Both registers sit on a single-byte bus port with combinational read data. The enable register is never written directly. Each enable write is a command: the top data bit picks set or clear, and the low seven bits select which enable bits the command affects. When the flag register is read, its top bit is a live summary that shows whether any enabled flag is pending. Each bus cycle is decoded into one access kind: idle, flag read, flag write, enable read, enable write, or an unmapped access. An unmapped access has no effect and reads as zero. The interrupt output is registered, so it follows the flag and enable state one cycle later.

Top module: `irq_setclr_unit`

## Requirements
- R1: `irq_o` is 1 exactly when the flag and enable registers, as they stood one clock earlier, share at least one set bit. After any flag or enable change it updates on the following clock edge, and it is never combinational from the inputs.
- R2: A read of the flag address (default 4'h2) returns the stored flags in bits 6..0. Bit 7 is 1 when the bitwise AND of the current flags and enables is nonzero, and 0 otherwise.
- R3: A write to the flag address clears each flag bit whose data bit is 1. Flag bits whose data bit is 0 keep their value.
- R4: A write to the enable address (default 4'h3) with data bit 7 = 1 ORs data bits 6..0 into the enable register.
- R5: A write to the enable address with data bit 7 = 0 clears each enable bit whose data bit is 1. The other enable bits are unchanged.
- R6: A read of the enable address returns the enable register in bits 6..0, with bit 7 always 1.
- R7: Reset (`rst_n` low) clears the flag register, the enable register and `irq_o` to 0.
- R8: Set pulses set these flag bits: `t1_set` sets bit 6, `t2_set` sets bit 5 and `sr_set` sets bit 2. The clear strobes `t1_clr`, `t2_clr` and `sr_clr` clear the same bits.
- R9: If a source's set pulse and a clear of the same flag (by flag write or by clear strobe) arrive in the same cycle, the flag ends up set.
- R10: Stored flag bits 4, 3, 1 and 0 always read 0.
- R11: A read of any other address returns 0x00. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| t1_set | input | 1 | Timer 1 event pulse |
| t2_set | input | 1 | Timer 2 event pulse |
| sr_set | input | 1 | Shift register event pulse |
| t1_clr | input | 1 | Timer 1 acknowledge strobe |
| t2_clr | input | 1 | Timer 2 acknowledge strobe |
| sr_clr | input | 1 | Shift register acknowledge strobe |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
A source's set pulse can land in the same cycle as a clear of the same flag. The clear can come from a software flag write with a one in that bit, or from the source's own acknowledge strobe. The bench provokes both collisions for the timer 1 and shift register bits by driving the pulse and the clear during the same low clock phase. It then judges the result by reading the flag register, which must show the bit still set with the pending summary at 1, and one cycle later by `irq_o`, which must be high. A second directed case checks that `irq_o` still shows the old state in the cycle right after a flag sets, and shows the new state only one edge later.

// File: rtl/irq_setclr_pkg.sv
package irq_setclr_pkg;
    localparam int DATA_W  = 8;
    localparam int FLAG_W  = 7;
    localparam int T1_BIT  = 6;
    localparam int T2_BIT  = 5;
    localparam int SR_BIT  = 2;
    localparam int NUM_SRC = 3;
    localparam logic [FLAG_W-1:0] LIVE_MASK =
        FLAG_W'((1 << T1_BIT) | (1 << T2_BIT) | (1 << SR_BIT));

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_FLAG_RD,
        ACC_FLAG_WR,
        ACC_ENA_RD,
        ACC_ENA_WR,
        ACC_UNMAPPED
    } access_e;

    function automatic int src_bit(input int idx);
        case (idx)
            0:       return T1_BIT;
            1:       return T2_BIT;
            default: return SR_BIT;
        endcase
    endfunction
endpackage

// File: rtl/irq_access_decode.sv
module irq_access_decode
    import irq_setclr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 2,
    parameter logic [ADDR_W-1:0] ENA_ADDR  = 3
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output access_e           kind_o
);
    always_comb begin
        if (!sel_i)
            kind_o = ACC_IDLE;
        else if (addr_i == FLAG_ADDR)
            kind_o = wr_i ? ACC_FLAG_WR : ACC_FLAG_RD;
        else if (addr_i == ENA_ADDR)
            kind_o = wr_i ? ACC_ENA_WR : ACC_ENA_RD;
        else
            kind_o = ACC_UNMAPPED;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_setclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flag_o
);
    logic [FLAG_W-1:0] flag_q;
    logic [FLAG_W-1:0] flag_d;

    always_comb flag_d = ((flag_q & ~clr_i) | set_i) & LIVE_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & LIVE_MASK)) |=> ((flag_q & $past(set_i & LIVE_MASK)) == $past(set_i & LIVE_MASK)));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q & ~LIVE_MASK) == '0);

    assert_clear_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((flag_q & ~$past(flag_q)) == '0));
endmodule

// File: rtl/irq_enable_bank.sv
module irq_enable_bank
    import irq_setclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [FLAG_W-1:0] ena_o
);
    logic [FLAG_W-1:0] ena_q;
    logic [FLAG_W-1:0] ena_d;
    logic              set_mode;

    assign set_mode = data_i[DATA_W-1];

    always_comb begin
        ena_d = ena_q;
        if (cmd_i) begin
            if (set_mode) ena_d = ena_q | data_i[FLAG_W-1:0];
            else          ena_d = ena_q & ~data_i[FLAG_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ena_q <= '0;
        else        ena_q <= ena_d;
    end

    assign ena_o = ena_q;

    assert_set_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && set_mode) |=> (ena_q == ($past(ena_q) | $past(data_i[FLAG_W-1:0]))));

    assert_clr_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i && !set_mode) |=> ((ena_q & $past(data_i[FLAG_W-1:0])) == '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_i |=> $stable(ena_q));
endmodule

// File: rtl/irq_level_out.sv
module irq_level_out
    import irq_setclr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [FLAG_W-1:0] ena_i,
    output logic              pend_o,
    output logic              irq_o
);
    logic irq_q;

    assign pend_o = |(flag_i & ena_i);

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_o;
    end

    assign irq_o = irq_q;

    assert_irq_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(|(flag_i & ena_i)));

    assert_irq_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> !$past(|(flag_i & ena_i)));
endmodule

// File: rtl/irq_setclr_unit.sv
module irq_setclr_unit
    import irq_setclr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 2,
    parameter logic [ADDR_W-1:0] ENA_ADDR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              t1_set,
    input  logic              t2_set,
    input  logic              sr_set,
    input  logic              t1_clr,
    input  logic              t2_clr,
    input  logic              sr_clr,
    output logic              irq_o
);
    access_e           kind;
    logic [NUM_SRC-1:0] src_set;
    logic [NUM_SRC-1:0] src_clr;
    logic [FLAG_W-1:0]  set_vec;
    logic [FLAG_W-1:0]  strobe_vec;
    logic [FLAG_W-1:0]  clr_vec;
    logic [FLAG_W-1:0]  flags;
    logic [FLAG_W-1:0]  enables;
    logic               pending;
    logic               ena_cmd;

    assign src_set = {sr_set, t2_set, t1_set};
    assign src_clr = {sr_clr, t2_clr, t1_clr};

    irq_access_decode #(
        .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR), .ENA_ADDR(ENA_ADDR)
    ) u_dec (
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .kind_o(kind)
    );

    always_comb begin
        set_vec    = '0;
        strobe_vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            set_vec[src_bit(i)]    = src_set[i];
            strobe_vec[src_bit(i)] = src_clr[i];
        end
    end

    always_comb begin
        clr_vec = strobe_vec;
        if (kind == ACC_FLAG_WR) clr_vec = strobe_vec | bus_wdata[FLAG_W-1:0];
    end

    assign ena_cmd = (kind == ACC_ENA_WR);

    irq_flag_bank u_flags (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .flag_o(flags)
    );

    irq_enable_bank u_ena (
        .clk(clk), .rst_n(rst_n), .cmd_i(ena_cmd), .data_i(bus_wdata), .ena_o(enables)
    );

    irq_level_out u_out (
        .clk(clk), .rst_n(rst_n), .flag_i(flags), .ena_i(enables),
        .pend_o(pending), .irq_o(irq_o)
    );

    always_comb begin
        unique case (kind)
            ACC_FLAG_RD:  bus_rdata = {pending, flags};
            ACC_ENA_RD:   bus_rdata = {1'b1, enables};
            ACC_IDLE,
            ACC_FLAG_WR,
            ACC_ENA_WR,
            ACC_UNMAPPED: bus_rdata = 8'h00;
            default:      bus_rdata = 8'h00;
        endcase
    end

    assert_ena_rd_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_ENA_RD) |-> bus_rdata[7]);

    assert_summary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_FLAG_RD) |-> (bus_rdata[7] == |(bus_rdata[6:0] & enables)));

    assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_UNMAPPED) |=> ($stable(enables) && ((flags & ~$past(flags)) == ($past(set_vec) & ~$past(flags)))));

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && enables == '0 && !irq_o));
endmodule

// File: tb/sim_irq_setclr_unit.sv
module sim_irq_setclr_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       t1_set = 0, t2_set = 0, sr_set = 0;
    logic       t1_clr = 0, t2_clr = 0, sr_clr = 0;
    logic       irq_o;
    int checks = 0, errors = 0;
    bit done = 0;

    localparam logic [3:0] FA = 4'h2, EA = 4'h3;

    always #10 clk = ~clk;

    irq_setclr_unit u0 (.*);

    // kind[1:0]: 0 flag write, 1 enable write, 2 set pulses, 3 clear strobes
    // source mask bits: 0 timer1, 1 timer2, 2 shift register
    // {kind, data, exp flag read, exp enable read, exp irq}
    localparam int NV = 12;
    localparam logic [26:0] VEC [NV] = '{
        {2'd2, 8'h01, 8'h40, 8'h80, 1'b0},
        {2'd1, 8'hC0, 8'hC0, 8'hC0, 1'b1},
        {2'd2, 8'h06, 8'hE4, 8'hC0, 1'b1},
        {2'd0, 8'h40, 8'h24, 8'hC0, 1'b0},
        {2'd1, 8'hA4, 8'hA4, 8'hE4, 1'b1},
        {2'd3, 8'h02, 8'h84, 8'hE4, 1'b1},
        {2'd1, 8'h04, 8'h04, 8'hE0, 1'b0},
        {2'd0, 8'h00, 8'h04, 8'hE0, 1'b0},
        {2'd1, 8'h00, 8'h04, 8'hE0, 1'b0},
        {2'd1, 8'hFF, 8'h84, 8'hFF, 1'b1},
        {2'd0, 8'hFF, 8'h00, 8'hFF, 1'b0},
        {2'd1, 8'h7F, 8'h00, 8'h80, 1'b0}
    };
    localparam string VTAG [NV] = '{"R8","R4","R8","R3","R4","R8",
                                    "R5","R3","R5","R4","R3","R5"};

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr_drive(input logic [3:0] a, input logic [7:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle_inputs();
        bus_sel = 0; bus_wr = 0; bus_wdata = 0;
        {t1_set, t2_set, sr_set, t1_clr, t2_clr, sr_clr} = '0;
    endtask

    task automatic cycle();
        @(negedge clk);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) cycle();
        rst_n = 1;
        cycle();
        // R7 reset state
        rd(FA, v); check("R7 flag after reset", v, 8'h00);
        rd(EA, v); check("R7 enable after reset (R6 top bit)", v, 8'h80);
        check("R7 irq after reset", {7'b0, irq_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [1:0] k; logic [7:0] d;
            k = VEC[i][26:25]; d = VEC[i][24:17];
            case (k)
                2'd0: wr_drive(FA, d);
                2'd1: wr_drive(EA, d);
                2'd2: {sr_set, t2_set, t1_set} = d[2:0];
                default: {sr_clr, t2_clr, t1_clr} = d[2:0];
            endcase
            cycle();
            idle_inputs();
            cycle();
            rd(FA, v); check({VTAG[i], " R2 flag read"}, v, VEC[i][16:9]);
            rd(EA, v); check({VTAG[i], " R6 enable read"}, v, VEC[i][8:1]);
            check({VTAG[i], " R1 irq level"}, {7'b0, irq_o}, {7'b0, VEC[i][0]});
        end

        // R1 latency: enable timer1, then pulse it
        wr_drive(EA, 8'hC0); cycle(); idle_inputs(); cycle();
        t1_set = 1; cycle(); idle_inputs();
        check("R1 irq still low one edge after set", {7'b0, irq_o}, 8'h00);
        cycle();
        check("R1 irq high two edges after set", {7'b0, irq_o}, 8'h01);

        // R9 set vs software clear in same cycle
        wr_drive(FA, 8'h40); t1_set = 1; cycle(); idle_inputs();
        rd(FA, v); check("R9 set beats flag write", v, 8'hC0);
        cycle();
        check("R9 irq stays high", {7'b0, irq_o}, 8'h01);

        // R9 set vs strobe on shift register bit
        sr_set = 1; sr_clr = 1; cycle(); idle_inputs();
        rd(FA, v); check("R9 set beats strobe", v, 8'hC4);

        // R8 strobe clears timer1 only
        t1_clr = 1; cycle(); idle_inputs();
        rd(FA, v); check("R8 timer1 strobe clears bit6", v, 8'h04);
        cycle();
        check("R1 irq falls after clear", {7'b0, irq_o}, 8'h00);

        // R10 writes cannot set unused flags
        wr_drive(FA, 8'h1B); cycle(); idle_inputs();
        rd(FA, v); check("R10 unused flag bits zero", v & 8'h1B, 8'h00);

        // R11 unmapped address
        wr_drive(4'h7, 8'hFF); cycle(); idle_inputs();
        rd(4'h7, v); check("R11 unmapped read", v, 8'h00);
        rd(EA, v); check("R11 unmapped write ignored (enable)", v, 8'hC0);
        rd(FA, v); check("R11 unmapped write ignored (flag)", v, 8'h04);

        // R7 reset mid-state
        t2_set = 1; cycle(); idle_inputs();
        rst_n = 0; cycle(); rst_n = 1;
        rd(FA, v); check("R7 flags cleared by reset", v, 8'h00);
        rd(EA, v); check("R7 enables cleared by reset", v, 8'h80);
        check("R7 irq cleared by reset", {7'b0, irq_o}, 8'h00);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule